// File: doc/BRIEF.md
# Match-Register PWM Timer

This block is a free-running up-counter whose wrap point is set by a programmable limit register. Two pairs of match registers sit beside it. On each enabled tick the current count is compared with every match value: a hit on a "set" value drives the modulated output high, and a hit on a "clear" value drives it low. Moving the limit changes the output period. Moving the match values changes pulse width or pulse position. Any match can also be enabled to raise a sticky interrupt flag.

Software configures the block byte by byte over a simple write bus. A DMA engine can instead reload every timing value through one address. Each write to that address goes to the next byte of the register set in a fixed order. New limit and match values are held in a staging copy and only become active when the counter wraps, so a period that is already running always finishes with the values it started with.

Top module: `pwm_match_timer`

## Requirements
- R1: After reset, `count_o`, `pwm_o` and `irq_o` are 0. The limit, all four match values and all interrupt enables are 0, both staged and active.
- R2: `count_o` rises by one on the clock edge after a cycle with `tick_en` high, and holds its value when `tick_en` is low.
- R3: The count runs from 0 up to the active limit inclusive. A tick taken at the limit returns it to 0.
- R4: On a tick where the count equals set value k, `pwm_o` becomes 1 at the next edge. When the count equals clear value k, `pwm_o` becomes 0. With no match, or with no tick, `pwm_o` holds its value.
- R5: If a set match and a clear match happen on the same tick, `pwm_o` becomes 0.
- R6: `irq_o` becomes 1 after a tick on which a match happens and that match's enable bit is set. Enable bit 2k belongs to set k and bit 2k+1 belongs to clear k. A match whose bit is 0 raises nothing.
- R7: `irq_o` stays 1 until a write to address 11 with data bit 0 equal to 1. If an enabled match happens in the same cycle as that clear, the flag stays 1.
- R8: Writes to address 12 fill staged bytes in this order: limit low, limit high, set0 low, set0 high, clear0 low, clear0 high, set1 low, set1 high, clear1 low, clear1 high. After the tenth byte the next write returns to limit low.
- R9: Any write to addresses 0 to 11 sends the address-12 sequence back to limit low.
- R10: Staged values are copied to the active set only on a wrap tick. A write made in the same cycle as a wrap takes effect at the following wrap.
- R11: Addresses 0 to 9 write the staged bytes directly, in the same byte order as R8. Address 10 writes the four enable bits from data bits 3:0, and those bits take effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable for this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Byte address (0-9 staged bytes, 10 enables, 11 clear, 12 auto-step port) |
| wr_data | input | 8 | Write data byte |
| count_o | output | 16 | Current counter value |
| pwm_o | output | 1 | Modulated status output |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
Two events can land in the same cycle and race for the same state. A set match and a clear match can both hit on one count, and a clear write can arrive on the very tick where an enabled match fires. The bench causes the first case by programming a set value equal to a clear value and stepping the counter through that count. It causes the second by issuing the clear write together with the matching tick. In the first case `pwm_o` must end at 0. In the second, `irq_o` must stay 1. Random traffic that mixes ticks, direct writes and auto-step writes is compared every cycle against a reference model in the bench.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam int BYTE_W = 8;

  function automatic int bytes_for(input int width);
    return (width + BYTE_W - 1) / BYTE_W;
  endfunction

  // Register slot numbering inside the staged/active word arrays
  function automatic int slot_set(input int k);
    return 1 + 2 * k;
  endfunction

  function automatic int slot_clr(input int k);
    return 2 + 2 * k;
  endfunction
endpackage

// File: rtl/pmt_regs.sv
module pmt_regs
  import pmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NPAIR  = 2,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [(1+2*NPAIR)*CNT_W-1:0] stg_flat,
  output logic [2*NPAIR-1:0]         ien,
  output logic                       clr_req
);
  localparam int BPR    = bytes_for(CNT_W);
  localparam int NREG   = 1 + 2 * NPAIR;
  localparam int NBYTES = NREG * BPR;
  localparam int PTR_W  = $clog2(NBYTES);
  localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(NBYTES);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(NBYTES + 1);
  localparam logic [ADDR_W-1:0] A_BLK = ADDR_W'(NBYTES + 2);
  localparam logic [PTR_W-1:0]  P_LAST = PTR_W'(NBYTES - 1);

  logic [BYTE_W-1:0]     stg_b [NBYTES];
  logic [PTR_W-1:0]      ptr;
  logic [NBYTES*BYTE_W-1:0] wide;
  logic                  blk_hit, dir_hit, byte_hit;
  logic [PTR_W-1:0]      idx;

  assign blk_hit  = wr_en && (wr_addr == A_BLK);
  assign dir_hit  = wr_en && (wr_addr < A_BLK);
  assign byte_hit = blk_hit || (wr_en && (wr_addr < A_IEN));
  assign idx      = blk_hit ? ptr : wr_addr[PTR_W-1:0];
  assign clr_req  = wr_en && (wr_addr == A_CLR) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++) stg_b[i] <= '0;
    end else if (byte_hit) begin
      stg_b[idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      ien <= '0;
    end else begin
      if (dir_hit) ptr <= '0;
      else if (blk_hit) ptr <= (ptr == P_LAST) ? '0 : ptr + PTR_W'(1);
      if (wr_en && (wr_addr == A_IEN)) ien <= wr_data[2*NPAIR-1:0];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NBYTES; g++) begin : g_pack
      assign wide[g*BYTE_W +: BYTE_W] = stg_b[g];
    end
    for (g = 0; g < NREG; g++) begin : g_slot
      assign stg_flat[g*CNT_W +: CNT_W] = wide[g*BPR*BYTE_W +: CNT_W];
    end
  endgenerate

  a_r9_ptr_home: assert property (@(posedge clk) disable iff (rst)
    dir_hit |=> (ptr == '0));
  a_r8_ptr_range: assert property (@(posedge clk) disable iff (rst)
    ptr <= P_LAST);
  a_r8_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (blk_hit && ptr != P_LAST) |=> (ptr == $past(ptr) + PTR_W'(1)));
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter
  import pmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NPAIR = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic [(1+2*NPAIR)*CNT_W-1:0] stg_flat,
  output logic [CNT_W-1:0]             cnt,
  output logic [(1+2*NPAIR)*CNT_W-1:0] act_flat
);
  logic [CNT_W-1:0] lim;
  logic             wrap;

  assign lim  = act_flat[CNT_W-1:0];
  assign wrap = tick && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      act_flat <= '0;
    end else if (tick) begin
      if (wrap) begin
        cnt      <= '0;
        act_flat <= stg_flat;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == lim) |=> (cnt == '0));
  a_r3_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim);
  a_r10_shadow: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act_flat));
endmodule

// File: rtl/pmt_match.sv
module pmt_match
  import pmt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NPAIR = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [(1+2*NPAIR)*CNT_W-1:0] act_flat,
  input  logic [2*NPAIR-1:0]           ien,
  input  logic                         clr_req,
  output logic                         pwm,
  output logic                         irq
);
  logic [NPAIR-1:0]   set_hit, clr_hit;
  logic [2*NPAIR-1:0] hit;
  logic               any_set, any_clr, irq_ev;

  genvar k;
  generate
    for (k = 0; k < NPAIR; k++) begin : g_pair
      assign set_hit[k]   = (cnt == act_flat[slot_set(k)*CNT_W +: CNT_W]);
      assign clr_hit[k]   = (cnt == act_flat[slot_clr(k)*CNT_W +: CNT_W]);
      assign hit[2*k]     = set_hit[k];
      assign hit[2*k+1]   = clr_hit[k];
    end
  endgenerate

  assign any_set = tick && (|set_hit);
  assign any_clr = tick && (|clr_hit);
  assign irq_ev  = tick && (|(hit & ien));

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (any_clr)      pwm <= 1'b0;
      else if (any_set) pwm <= 1'b1;
      if (irq_ev)       irq <= 1'b1;
      else if (clr_req) irq <= 1'b0;
    end
  end

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
    any_clr |=> !pwm);
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pwm));
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_req) |=> irq);
  a_r7_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (irq_ev && clr_req) |=> irq);
endmodule

// File: rtl/pwm_match_timer.sv
module pwm_match_timer
  import pmt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NPAIR  = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [CNT_W-1:0]  count_o,
  output logic              pwm_o,
  output logic              irq_o
);
  localparam int NREG = 1 + 2 * NPAIR;

  logic [NREG*CNT_W-1:0] stg_flat, act_flat;
  logic [2*NPAIR-1:0]    ien;
  logic                  clr_req;

  pmt_regs #(.CNT_W(CNT_W), .NPAIR(NPAIR), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .stg_flat(stg_flat), .ien(ien), .clr_req(clr_req)
  );

  pmt_counter #(.CNT_W(CNT_W), .NPAIR(NPAIR)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_en), .stg_flat(stg_flat),
    .cnt(count_o), .act_flat(act_flat)
  );

  pmt_match #(.CNT_W(CNT_W), .NPAIR(NPAIR)) u_match (
    .clk(clk), .rst(rst), .tick(tick_en), .cnt(count_o),
    .act_flat(act_flat), .ien(ien), .clr_req(clr_req),
    .pwm(pwm_o), .irq(irq_o)
  );
endmodule

// File: tb/sim_pwm_match_timer.sv
module sim_pwm_match_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] count_o;
  logic        pwm_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int m_cnt, m_ptr, m_ien;
  bit m_pwm, m_irq;
  int m_stg [10];
  int m_act [5];

  always #4 clk = ~clk;

  pwm_match_timer u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count_o(count_o),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  function automatic int stg_word(input int r);
    return m_stg[2*r] + 256 * m_stg[2*r+1];
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_ptr = 0; m_ien = 0; m_pwm = 0; m_irq = 0;
    for (int i = 0; i < 10; i++) m_stg[i] = 0;
    for (int i = 0; i < 5; i++) m_act[i] = 0;
  endtask

  task automatic model_step(input bit tk, input bit we, input int a, input int d);
    bit sh, ch, ev;
    int hits;
    if (tk) begin
      sh = (m_cnt == m_act[1]) || (m_cnt == m_act[3]);
      ch = (m_cnt == m_act[2]) || (m_cnt == m_act[4]);
      hits = ((m_cnt == m_act[1]) ? 1 : 0) | ((m_cnt == m_act[2]) ? 2 : 0) |
             ((m_cnt == m_act[3]) ? 4 : 0) | ((m_cnt == m_act[4]) ? 8 : 0);
      ev = (hits & m_ien) != 0;
      if (ch) m_pwm = 0;
      else if (sh) m_pwm = 1;
      if (m_cnt == m_act[0]) begin
        m_cnt = 0;
        for (int r = 0; r < 5; r++) m_act[r] = stg_word(r);
      end else m_cnt = m_cnt + 1;
    end else ev = 0;
    if (ev) m_irq = 1;
    else if (we && a == 11 && d[0]) m_irq = 0;
    if (we) begin
      if (a < 10) begin m_stg[a] = d & 255; m_ptr = 0; end
      else if (a == 10) begin m_ien = d & 15; m_ptr = 0; end
      else if (a == 11) m_ptr = 0;
      else if (a == 12) begin
        m_stg[m_ptr] = d & 255;
        m_ptr = (m_ptr == 9) ? 0 : m_ptr + 1;
      end
    end
  endtask

  task automatic step(input bit tk, input bit we, input int a, input int d);
    @(negedge clk);
    tick_en = tk; wr_en = we; wr_addr = a[3:0]; wr_data = d[7:0];
    @(posedge clk);
    model_step(tk, we, a, d);
    #1;
    chk("R2/R3/R10 count", count_o, m_cnt);
    chk("R4/R5/R8/R11 pwm", pwm_o, m_pwm);
    chk("R6/R7 irq", irq_o, m_irq);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 count after reset", count_o, 0);
    chk("R1 pwm after reset", pwm_o, 0);
    chk("R1 irq after reset", irq_o, 0);

    // R8: auto-step load: limit 7, set0 2, clr0 5, set1 9, clr1 9
    step(1, 1, 12, 7);  step(0, 1, 12, 0);
    step(0, 1, 12, 2);  step(0, 1, 12, 0);
    step(0, 1, 12, 5);  step(0, 1, 12, 0);
    step(0, 1, 12, 9);  step(0, 1, 12, 0);
    step(0, 1, 12, 9);  step(0, 1, 12, 0);
    chk("R10 limit-0 wrap with write in same cycle", count_o, 0);
    ticks(1);   // wrap loads staged values
    chk("R10 wrap loads staged set", count_o, 0);
    ticks(3);
    chk("R8 R4 set0 match drives pwm high count", count_o, 3);
    chk("R4 pwm high after set match", pwm_o, 1);
    ticks(3);
    chk("R4 pwm low after clear match", pwm_o, 0);
    chk("R2 count advanced", count_o, 6);
    ticks(2);
    chk("R3 wrap after limit 7", count_o, 0);
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    chk("R2 count holds without tick", count_o, 0);

    // R5 + R11: set1 = 5 equals clr0 = 5
    step(0, 1, 6, 5); step(0, 1, 7, 0);
    ticks(8);
    chk("R10 old period completes", count_o, 0);
    ticks(3);
    chk("R5 pwm set before coincidence", pwm_o, 1);
    ticks(3);
    chk("R5 clear wins over set on same count", pwm_o, 0);

    // R10: shorten limit mid-period
    step(0, 1, 0, 3);
    ticks(1);
    chk("R10 limit change waits for wrap", count_o, 7);
    ticks(1);
    chk("R10 wrap at old limit", count_o, 0);
    ticks(4);
    chk("R3 new limit 3 wraps after 4 ticks", count_o, 0);

    // R6 / R7
    step(0, 1, 10, 1);    // enable set0 only
    ticks(2);
    chk("R6 no irq before match", irq_o, 0);
    ticks(1);
    chk("R6 irq on enabled set0 match", irq_o, 1);
    step(0, 1, 11, 0);
    chk("R7 write without bit0 leaves flag", irq_o, 1);
    step(0, 1, 11, 1);
    chk("R7 clear by writing bit0", irq_o, 0);
    ticks(3);             // count 3 -> 0 -> 1 -> 2
    chk("R7 counter at match point", count_o, 2);
    step(1, 1, 11, 1);    // clear together with enabled match
    chk("R7 set wins over clear", irq_o, 1);
    step(0, 1, 11, 1);
    step(0, 1, 10, 8);    // enable clr1 only (value 9, unreachable)
    ticks(8);
    chk("R6 disabled matches raise nothing", irq_o, 0);

    // R9: partial auto-step then direct write restarts sequence
    step(0, 1, 12, 9); step(0, 1, 12, 0); step(0, 1, 12, 1);
    step(0, 1, 10, 0);
    step(0, 1, 12, 5); step(0, 1, 12, 0);
    while (count_o != 16'd3) ticks(1);
    ticks(1);             // wrap loads limit 5
    ticks(5);
    chk("R9 count before wrap at limit 5", count_o, 5);
    ticks(1);
    chk("R9 sequence restarted at limit low byte", count_o, 0);

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      bit tk, we;
      int a, d, idx;
      tk = ($urandom % 4) != 0;
      we = ($urandom % 6) == 0;
      a  = $urandom % 13;
      idx = (a == 12) ? m_ptr : a;
      if (idx < 10) d = (idx % 2 == 1) ? 0 : ($urandom % 20);
      else if (a == 10) d = $urandom % 16;
      else d = $urandom % 2;
      step(tk, we, a, d);
    end

    finish_run();
  end
endmodule